// File: doc/BRIEF.md
# Dual-Port RAM with Write-Inhibit Input

This block is a 2048-word by 8-bit memory that two independent agents, the left side and the right side, can reach at the same time. Each side has its own address, an active-low select, a read/write control, an active-low output enable, a write-data bus, a read-data bus and a read-valid flag. Either side can reach any location at any moment, without regard to what the other side is doing.

Each side also takes an active-low write-inhibit input. When it is low, a write from that side is thrown away and the memory is left unchanged. This lets the block act as one lane of a wider memory: a separate arbiter decides which side loses a collision, and every lane uses that decision to drop the losing write.

The block is fully synchronous. All accesses are taken at the rising clock edge. A disabled or high-impedance output is shown as a low read-valid flag with the read-data bus held at zero.

Top module: `dpram_busy_top`

## Requirements
- R1: A side stores its write data at its address on a rising edge when its select is low (0), its read/write control is low (0 = write) and its write-inhibit input is high; the output enable has no effect on writes.
- R2: A side with select low, read/write high (1 = read) and output enable low presents the addressed word on its read data, with read-valid high, one clock after that edge; read-valid is low in the cycle after a write.
- R3: With select high, a side neither writes nor reads, whatever its other controls are, and its read-valid is low in the next cycle.
- R4: A selected read with output enable high gives read-valid low and read data zero in the next cycle.
- R5: A write from a side whose write-inhibit input is low (0) leaves the memory unchanged.
- R6: A read in the same cycle as a write to the same address from the other side returns the old contents; a read in a later cycle returns the new word.
- R7: When both sides write the same address in one cycle and neither is inhibited, the left side's data is stored; when only the left side is inhibited, the right side's data is stored.
- R8: Both sides can read different addresses in the same cycle, and each gets its own word.
- R9: While reset is held, and in the first cycle after it is released, both read-valid flags are low and both read-data buses are zero.
- R10: The read-data bus of a side is zero in every cycle in which its read-valid flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lAddr | input | 11 | Left address |
| lSelN | input | 1 | Left select, active low |
| lReadWrite | input | 1 | Left direction: 1 read, 0 write |
| lOutEnN | input | 1 | Left output enable, active low |
| lBusyN | input | 1 | Left write inhibit, active low |
| lWrData | input | 8 | Left write data |
| lRdData | output | 8 | Left read data, zero when not valid |
| lRdValid | output | 1 | Left read data valid |
| rAddr | input | 11 | Right address |
| rSelN | input | 1 | Right select, active low |
| rReadWrite | input | 1 | Right direction: 1 read, 0 write |
| rOutEnN | input | 1 | Right output enable, active low |
| rBusyN | input | 1 | Right write inhibit, active low |
| rWrData | input | 8 | Right write data |
| rRdData | output | 8 | Right read data, zero when not valid |
| rRdValid | output | 1 | Right read data valid |

## Verification
A write takes effect at the edge that samples it, so it can be seen by a read sampled at the next edge. Read data and read-valid appear exactly one edge after the read controls are sampled. The bench therefore drives every input set just after a falling edge and checks the outputs at the next falling edge, halfway through the cycle that follows the accepting edge. The read-before-write and left-wins cases are checked in that same cycle, and read back once more one cycle later.

// File: rtl/dpram_pkg.sv
package dpram_pkg;
  // Strobes from the control decode to the storage datapath
  typedef struct packed {
    logic lWrite;
    logic lRead;
    logic rWrite;
    logic rRead;
  } portStrobes_t;
endpackage

// File: rtl/dpram_ctrl.sv
module dpram_ctrl
  import dpram_pkg::*;
(
  input  logic         lSelN,
  input  logic         lReadWrite,
  input  logic         lOutEnN,
  input  logic         lBusyN,
  input  logic         rSelN,
  input  logic         rReadWrite,
  input  logic         rOutEnN,
  input  logic         rBusyN,
  output portStrobes_t strobes
);
  // A write needs select, write direction and no inhibit; output enable is ignored.
  // A read needs select, read direction and output enable.
  always_comb begin
    strobes.lWrite = !lSelN && !lReadWrite && lBusyN;
    strobes.lRead  = !lSelN &&  lReadWrite && !lOutEnN;
    strobes.rWrite = !rSelN && !rReadWrite && rBusyN;
    strobes.rRead  = !rSelN &&  rReadWrite && !rOutEnN;
  end
endmodule

// File: rtl/dpram_array.sv
module dpram_array
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  portStrobes_t      strobes,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic [DATA_W-1:0] lWrData,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] lRdData,
  output logic              lRdValid,
  output logic [DATA_W-1:0] rRdData,
  output logic              rRdValid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] lHold, rHold;
  logic              lValid, rValid;

  // Right write first, left write last: on an address clash the left data is kept.
  always_ff @(posedge clk) begin
    if (strobes.rWrite) mem[rAddr] <= rWrData;
    if (strobes.lWrite) mem[lAddr] <= lWrData;
  end

  // Non-blocking reads pick up the contents before this edge's writes.
  always_ff @(posedge clk) begin
    if (strobes.lRead) lHold <= mem[lAddr];
    if (strobes.rRead) rHold <= mem[rAddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lValid <= 1'b0;
      rValid <= 1'b0;
    end else begin
      lValid <= strobes.lRead;
      rValid <= strobes.rRead;
    end
  end

  assign lRdValid = lValid;
  assign rRdValid = rValid;
  assign lRdData  = lValid ? lHold : '0;
  assign rRdData  = rValid ? rHold : '0;
endmodule

// File: rtl/dpram_busy_top.sv
module dpram_busy_top
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lSelN,
  input  logic              lReadWrite,
  input  logic              lOutEnN,
  input  logic              lBusyN,
  input  logic [DATA_W-1:0] lWrData,
  output logic [DATA_W-1:0] lRdData,
  output logic              lRdValid,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rSelN,
  input  logic              rReadWrite,
  input  logic              rOutEnN,
  input  logic              rBusyN,
  input  logic [DATA_W-1:0] rWrData,
  output logic [DATA_W-1:0] rRdData,
  output logic              rRdValid
);
  portStrobes_t strobes;

  dpram_ctrl u_ctrl (
    .lSelN(lSelN), .lReadWrite(lReadWrite), .lOutEnN(lOutEnN), .lBusyN(lBusyN),
    .rSelN(rSelN), .rReadWrite(rReadWrite), .rOutEnN(rOutEnN), .rBusyN(rBusyN),
    .strobes(strobes)
  );

  dpram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .lAddr(lAddr), .rAddr(rAddr), .lWrData(lWrData), .rWrData(rWrData),
    .lRdData(lRdData), .lRdValid(lRdValid), .rRdData(rRdData), .rRdValid(rRdValid)
  );
endmodule

// File: rtl/dpram_busy_chk.sv
module dpram_busy_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] lAddr,
  input logic              lSelN,
  input logic              lReadWrite,
  input logic              lOutEnN,
  input logic              lBusyN,
  input logic [DATA_W-1:0] lWrData,
  input logic [DATA_W-1:0] lRdData,
  input logic              lRdValid,
  input logic [ADDR_W-1:0] rAddr,
  input logic              rSelN,
  input logic              rReadWrite,
  input logic              rOutEnN,
  input logic              rBusyN,
  input logic [DATA_W-1:0] rWrData,
  input logic [DATA_W-1:0] rRdData,
  input logic              rRdValid
);
  logic lRd, rRd, lWr, rWr;
  assign lRd = !lSelN && lReadWrite && !lOutEnN;
  assign rRd = !rSelN && rReadWrite && !rOutEnN;
  assign lWr = !lSelN && !lReadWrite && lBusyN;
  assign rWr = !rSelN && !rReadWrite && rBusyN;

  // R2
  l_read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) lRd |=> lRdValid);
  // R2
  r_read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n) rRd |=> rRdValid);
  // R3
  l_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n) !lRd |=> !lRdValid);
  // R3
  r_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n) !rRd |=> !rRdValid);
  // R10
  l_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !lRdValid |-> lRdData == '0);
  // R10
  r_zero_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !rRdValid |-> rRdData == '0);
  // R1 R7: a left write is seen by a right read in the next cycle
  l_to_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rRd && $past(lWr) && $past(lAddr) == rAddr) |=> rRdData == $past(lWrData, 2));
  // R1: a right write, unopposed at that address, is seen by a left read next cycle
  r_to_l_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lRd && $past(rWr) && $past(rAddr) == lAddr && !($past(lWr) && $past(lAddr) == lAddr))
    |=> lRdData == $past(rWrData, 2));
endmodule

bind dpram_busy_top dpram_busy_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/dpram_busy_top_test.sv
`timescale 1ns/1ps
module dpram_busy_top_test;
  localparam int AW = 11;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] lAddr, rAddr;
  logic lSelN, lReadWrite, lOutEnN, lBusyN;
  logic rSelN, rReadWrite, rOutEnN, rBusyN;
  logic [DW-1:0] lWrData, rWrData;
  logic [DW-1:0] lRdData, rRdData;
  logic lRdValid, rRdValid;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] model [N];

  always #2.5 clk = ~clk;

  dpram_busy_top uut (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    lSelN = 1; lReadWrite = 1; lOutEnN = 0; lBusyN = 1; lAddr = '0; lWrData = '0;
    rSelN = 1; rReadWrite = 1; rOutEnN = 0; rBusyN = 1; rAddr = '0; rWrData = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] patA(int a);
    return DW'((a * 37 + 5) ^ (a >> 3));
  endfunction

  function automatic logic [DW-1:0] patB(int a);
    return DW'(a * 11 + 200);
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) tick();
    // R9 while reset is held
    check("R9 lRdValid in reset", lRdValid, 0);
    check("R9 rRdData in reset", rRdData, 0);
    rst_n = 1;
    tick();
    check("R9 lRdValid after reset", lRdValid, 0);
    check("R9 rRdValid after reset", rRdValid, 0);
    check("R9 lRdData after reset", lRdData, 0);
    check("R9 rRdData after reset", rRdData, 0);

    // R1: fill the array from the left, output enable high to show it is ignored
    for (int a = 0; a < N; a++) begin
      idle();
      lSelN = 0; lReadWrite = 0; lOutEnN = a[0]; lAddr = AW'(a); lWrData = patA(a);
      model[a] = patA(a);
      tick();
      if (a % 256 == 0) check("R2 lRdValid low after write", lRdValid, 0);
    end

    // R1 R2 R8: both sides read different addresses each cycle
    for (int a = 0; a < N; a++) begin
      idle();
      rSelN = 0; rAddr = AW'(a);
      lSelN = 0; lAddr = AW'(N - 1 - a);
      tick();
      check("R2 rRdValid", rRdValid, 1);
      check("R1 rRdData", rRdData, model[a]);
      check("R8 lRdData", lRdData, model[N - 1 - a]);
    end

    // R5: right writes, inhibited on odd addresses
    for (int a = 0; a < N; a++) begin
      idle();
      rSelN = 0; rReadWrite = 0; rAddr = AW'(a); rWrData = patB(a); rBusyN = ~a[0];
      if (!a[0]) model[a] = patB(a);
      tick();
    end
    for (int a = 0; a < N; a++) begin
      idle();
      lSelN = 0; lAddr = AW'(a);
      tick();
      check("R5 lRdData after inhibited write", lRdData, model[a]);
    end

    // R3 R10: deselected sides attempt writes and reads
    for (int a = 0; a < 64; a++) begin
      idle();
      lReadWrite = 0; lAddr = AW'(a); lWrData = 8'hA5;
      rReadWrite = a[0]; rAddr = AW'(a); rWrData = 8'h5A;
      tick();
      check("R3 lRdValid deselected", lRdValid, 0);
      check("R3 rRdValid deselected", rRdValid, 0);
      check("R10 lRdData zero", lRdData, 0);
    end
    for (int a = 0; a < 64; a++) begin
      idle();
      rSelN = 0; rAddr = AW'(a);
      tick();
      check("R3 memory unchanged", rRdData, model[a]);
    end

    // R4: selected read with output enable high
    for (int a = 0; a < 16; a++) begin
      idle();
      lSelN = 0; lOutEnN = 1; lAddr = AW'(a);
      rSelN = 0; rOutEnN = 1; rAddr = AW'(a + 5);
      tick();
      check("R4 lRdValid", lRdValid, 0);
      check("R4 lRdData", lRdData, 0);
      check("R4 rRdValid", rRdValid, 0);
      check("R4 rRdData", rRdData, 0);
    end

    // R6: write on one side, read same address on the other in the same cycle
    for (int a = 100; a < 132; a++) begin
      logic [DW-1:0] oldV, newV;
      oldV = model[a];
      newV = DW'(a * 3 + 1);
      idle();
      if (a[0]) begin
        lSelN = 0; lReadWrite = 0; lAddr = AW'(a); lWrData = newV;
        rSelN = 0; rAddr = AW'(a);
      end else begin
        rSelN = 0; rReadWrite = 0; rAddr = AW'(a); rWrData = newV;
        lSelN = 0; lAddr = AW'(a);
      end
      model[a] = newV;
      tick();
      check("R6 old data same cycle", a[0] ? rRdData : lRdData, oldV);
      idle();
      lSelN = 0; lAddr = AW'(a);
      rSelN = 0; rAddr = AW'(a);
      tick();
      check("R6 new data next cycle L", lRdData, newV);
      check("R6 new data next cycle R", rRdData, newV);
    end

    // R7: both sides write the same address
    for (int a = 200; a < 216; a++) begin
      idle();
      lSelN = 0; lReadWrite = 0; lAddr = AW'(a); lWrData = DW'(a + 1);
      rSelN = 0; rReadWrite = 0; rAddr = AW'(a); rWrData = DW'(a + 77);
      lBusyN = a[0];
      model[a] = a[0] ? DW'(a + 1) : DW'(a + 77);
      tick();
      idle();
      rSelN = 0; rAddr = AW'(a);
      tick();
      check("R7 collision winner", rRdData, model[a]);
    end

    idle();
    tick();
    finish_run();
  end
endmodule